// File: doc/BRIEF.md
# Masked Compare Conditional Jump Unit

This unit resolves one conditional jump for a small script-driven I/O sequencer. An instruction pair is presented on two 32-bit inputs. The first word carries an 8-bit reference value and an 8-bit exclusion mask. The second word carries a 32-bit jump target. When the sequencer pulses the evaluate strobe, the unit compares the reference value against the byte captured as the first one received from the peripheral bus. Bit positions whose mask bit is 1 are left out of the compare.

When the compare fails, the unit steps the instruction pointer over both instruction words and signals completion. When it succeeds, the unit requests a fetch of the target instruction and holds that request until memory reports ready. It then loads the pointer with the target plus four and signals completion. The compare result stays on an output until the next accepted evaluation.

Top module: `mcj_unit`

## Requirements
- R1: Bits 7:0 of `word0_i` are the reference value and bits 15:8 are the exclusion mask; bits 31:16 of `word0_i` have no effect; `word1_i` is the jump target.
- R2: A bit counts toward the compare only where the mask bit is 0; the compare hits when every such bit of `rx_byte_i` equals the same bit of the reference value (mask 0xFF always hits).
- R3: `match_o` is loaded with the compare result on the clock edge that accepts `eval_i` and keeps its value until the next accepted evaluation.
- R4: On a miss, `ip_o` equals its old value plus 8 one cycle after the strobe; `done_o` is high in that cycle and `fetch_req_o` stays low.
- R5: On a hit, `fetch_req_o` is high from the cycle after the strobe, with `fetch_addr_o` equal to the target; both hold, and `ip_o` stays unchanged, until `fetch_rdy_i` is sampled high.
- R6: On the edge where `fetch_req_o` and `fetch_rdy_i` are both high, `ip_o` becomes the target plus 4, `fetch_req_o` drops and `done_o` goes high for the next cycle.
- R7: `eval_i` is ignored while a fetch request is pending: match, pointer and fetch address are unchanged.
- R8: During reset `ip_o` is 0 (`RESET_PTR`), and `match_o`, `fetch_req_o` and `done_o` are 0.
- R9: `done_o` is a one-cycle pulse per completed jump decision and is never high while `fetch_req_o` is high.
- R10: Pointer arithmetic wraps modulo 2^32 (target 0xFFFFFFF8 lands at 0xFFFFFFFC, and a following miss gives 0x00000004).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| eval_i | input | 1 | Evaluate strobe for the presented instruction pair |
| word0_i | input | 32 | First instruction word (mask and reference value) |
| word1_i | input | 32 | Second instruction word (jump target) |
| rx_byte_i | input | 8 | Captured first-received byte |
| fetch_rdy_i | input | 1 | Memory ready for the pending fetch |
| match_o | output | 1 | Result of the last accepted compare |
| fetch_req_o | output | 1 | Fetch request for the jump target |
| fetch_addr_o | output | 32 | Address of the requested fetch |
| ip_o | output | 32 | Instruction pointer |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that `eval_i`, `fetch_rdy_i` and the instruction words are known and settled at every rising edge after reset is released. They also assume that `fetch_rdy_i` only has meaning while a request is pending. The bench changes inputs one time unit after a rising edge, so each value is stable for the following edge. It raises ready only while the request is up and lowers it again right after the handshake edge. During a pending fetch it deliberately strobes `eval_i` with different words, which probes the ignore rule without violating these premises.

// File: rtl/mcj_pkg.sv
package mcj_pkg;

  // sequencer phases of the jump unit
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } mcj_state_e;

  localparam int unsigned MCJ_WORD_W     = 32;
  localparam int unsigned MCJ_CMP_W      = 8;
  localparam int unsigned MCJ_SKIP_BYTES = 8;
  localparam int unsigned MCJ_LAND_BYTES = 4;

endpackage

// File: rtl/mcj_compare.sv
module mcj_compare #(
  parameter int unsigned CMP_W = 8
) (
  input  logic [CMP_W-1:0] value_i,
  input  logic [CMP_W-1:0] mask_i,
  input  logic [CMP_W-1:0] sample_i,
  output logic             hit_o
);

  // a set mask bit removes that position from the compare
  function automatic logic masked_equal(
    input logic [CMP_W-1:0] smp,
    input logic [CMP_W-1:0] ref_v,
    input logic [CMP_W-1:0] excl
  );
    logic [CMP_W-1:0] diff;
    diff = (smp ^ ref_v) & ~excl;
    return (diff == '0);
  endfunction

  assign hit_o = masked_equal(sample_i, value_i, mask_i);

endmodule

// File: rtl/mcj_seq.sv
module mcj_seq
  import mcj_pkg::*;
#(
  parameter int unsigned           ADDR_W     = 32,
  parameter logic [ADDR_W-1:0]     RESET_PTR  = '0,
  parameter int unsigned           SKIP_BYTES = 8,
  parameter int unsigned           LAND_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic              fetch_rdy_i,
  output logic              idle_o,
  output logic              land_o,
  output logic              match_o,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  output logic [ADDR_W-1:0] ip_o,
  output logic              done_o
);

  function automatic logic [ADDR_W-1:0] skip_next(input logic [ADDR_W-1:0] p);
    return p + ADDR_W'(SKIP_BYTES);
  endfunction

  function automatic logic [ADDR_W-1:0] land_next(input logic [ADDR_W-1:0] t);
    return t + ADDR_W'(LAND_BYTES);
  endfunction

  mcj_state_e        state_q;
  logic              match_q;
  logic              done_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [ADDR_W-1:0] ip_q;

  assign idle_o       = (state_q == ST_IDLE);
  assign fetch_req_o  = (state_q == ST_FETCH);
  assign land_o       = fetch_req_o & fetch_rdy_i;
  assign match_o      = match_q;
  assign done_o       = done_q;
  assign fetch_addr_o = tgt_q;
  assign ip_o         = ip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      match_q <= 1'b0;
      done_q  <= 1'b0;
      tgt_q   <= '0;
      ip_q    <= RESET_PTR;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept_i) begin
            match_q <= hit_i;
            if (hit_i) begin
              tgt_q   <= target_i;
              state_q <= ST_FETCH;
            end else begin
              ip_q   <= skip_next(ip_q);
              done_q <= 1'b1;
            end
          end
        end
        ST_FETCH: begin
          if (land_o) begin
            ip_q    <= land_next(tgt_q);
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mcj_unit.sv
module mcj_unit
  import mcj_pkg::*;
#(
  parameter int unsigned           WORD_W     = MCJ_WORD_W,
  parameter int unsigned           CMP_W      = MCJ_CMP_W,
  parameter logic [WORD_W-1:0]     RESET_PTR  = '0,
  parameter int unsigned           SKIP_BYTES = MCJ_SKIP_BYTES,
  parameter int unsigned           LAND_BYTES = MCJ_LAND_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              eval_i,
  input  logic [WORD_W-1:0] word0_i,
  input  logic [WORD_W-1:0] word1_i,
  input  logic [CMP_W-1:0]  rx_byte_i,
  input  logic              fetch_rdy_i,
  output logic              match_o,
  output logic              fetch_req_o,
  output logic [WORD_W-1:0] fetch_addr_o,
  output logic [WORD_W-1:0] ip_o,
  output logic              done_o
);

  localparam int unsigned ADDR_W   = WORD_W;
  localparam int unsigned FIELDS_W = 2 * CMP_W;

  // named internal events, observed by the bound checker
  logic             hit_w;
  logic             idle_w;
  logic             accept_w;
  logic             land_w;
  logic [CMP_W-1:0] cmp_value_w;
  logic [CMP_W-1:0] cmp_mask_w;

  assign cmp_value_w = word0_i[CMP_W-1:0];
  assign cmp_mask_w  = word0_i[FIELDS_W-1:CMP_W];
  assign accept_w    = eval_i & idle_w;

  generate
    if (FIELDS_W < WORD_W) begin : g_spare
      logic unused_spare;
      assign unused_spare = ^word0_i[WORD_W-1:FIELDS_W];
    end
  endgenerate

  mcj_compare #(
    .CMP_W (CMP_W)
  ) u_cmp (
    .value_i  (cmp_value_w),
    .mask_i   (cmp_mask_w),
    .sample_i (rx_byte_i),
    .hit_o    (hit_w)
  );

  mcj_seq #(
    .ADDR_W     (ADDR_W),
    .RESET_PTR  (RESET_PTR),
    .SKIP_BYTES (SKIP_BYTES),
    .LAND_BYTES (LAND_BYTES)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept_i     (accept_w),
    .hit_i        (hit_w),
    .target_i     (word1_i),
    .fetch_rdy_i  (fetch_rdy_i),
    .idle_o       (idle_w),
    .land_o       (land_w),
    .match_o      (match_o),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .ip_o         (ip_o),
    .done_o       (done_o)
  );

endmodule

// File: rtl/mcj_unit_chk.sv
module mcj_unit_chk #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned SKIP_BYTES = 8,
  parameter int unsigned LAND_BYTES = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              accept_w,
  input logic              hit_w,
  input logic              land_w,
  input logic              fetch_rdy_i,
  input logic [ADDR_W-1:0] word1_i,
  input logic              match_o,
  input logic              fetch_req_o,
  input logic [ADDR_W-1:0] fetch_addr_o,
  input logic [ADDR_W-1:0] ip_o,
  input logic              done_o
);

  // R4
  skip_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && !hit_w |=> done_o && !fetch_req_o && !match_o &&
      (ip_o == ADDR_W'($past(ip_o) + SKIP_BYTES)));

  // R5
  req_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w && hit_w |=> fetch_req_o && match_o && !done_o &&
      (fetch_addr_o == $past(word1_i)));

  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o && !fetch_rdy_i |=> fetch_req_o && $stable(fetch_addr_o) && $stable(ip_o));

  // R6
  land_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    land_w |=> !fetch_req_o && done_o &&
      (ip_o == ADDR_W'($past(fetch_addr_o) + LAND_BYTES)));

  // R7
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> !accept_w);

  // R3
  match_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_w |=> $stable(match_o));

  // R9
  done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_req_o |-> !done_o);

endmodule

bind mcj_unit mcj_unit_chk #(
  .ADDR_W     (ADDR_W),
  .SKIP_BYTES (SKIP_BYTES),
  .LAND_BYTES (LAND_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .accept_w     (accept_w),
  .hit_w        (hit_w),
  .land_w       (land_w),
  .fetch_rdy_i  (fetch_rdy_i),
  .word1_i      (word1_i),
  .match_o      (match_o),
  .fetch_req_o  (fetch_req_o),
  .fetch_addr_o (fetch_addr_o),
  .ip_o         (ip_o),
  .done_o       (done_o)
);

// File: tb/mcj_unit_tb.sv
module mcj_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        eval_i = 1'b0;
  logic [31:0] word0_i = '0;
  logic [31:0] word1_i = '0;
  logic [7:0]  rx_byte_i = '0;
  logic        fetch_rdy_i = 1'b0;
  logic        match_o;
  logic        fetch_req_o;
  logic [31:0] fetch_addr_o;
  logic [31:0] ip_o;
  logic        done_o;

  int          n_chk = 0;
  int          n_bad = 0;
  logic [31:0] exp_ip = '0;
  logic        exp_match = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mcj_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .eval_i       (eval_i),
    .word0_i      (word0_i),
    .word1_i      (word1_i),
    .rx_byte_i    (rx_byte_i),
    .fetch_rdy_i  (fetch_rdy_i),
    .match_o      (match_o),
    .fetch_req_o  (fetch_req_o),
    .fetch_addr_o (fetch_addr_o),
    .ip_o         (ip_o),
    .done_o       (done_o)
  );

  // bit-by-bit restatement: only unmasked positions must agree
  function automatic bit bench_hit(input logic [7:0] smp, input logic [7:0] val,
                                   input logic [7:0] msk);
    for (int i = 0; i < 8; i++) begin
      if (msk[i] == 1'b0 && smp[i] != val[i]) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // one full evaluation; busy_evals strobes eval_i with other words while the fetch waits
  task automatic run_eval(input string tag, input logic [15:0] spare, input logic [7:0] msk,
                          input logic [7:0] val, input logic [7:0] smp,
                          input logic [31:0] tgt, input int wait_n);
    bit hit;
    hit = bench_hit(smp, val, msk);
    word0_i   = {spare, msk, val};
    word1_i   = tgt;
    rx_byte_i = smp;
    eval_i    = 1'b1;
    step();
    eval_i = 1'b0;
    exp_match = hit;
    chk({tag, " R1/R2/R3 match"}, {31'd0, match_o}, {31'd0, hit});
    if (!hit) begin
      exp_ip = exp_ip + 32'd8;
      chk({tag, " R4 ip skip"}, ip_o, exp_ip);
      chk({tag, " R4 done"}, {31'd0, done_o}, 32'd1);
      chk({tag, " R4 no req"}, {31'd0, fetch_req_o}, 32'd0);
    end else begin
      chk({tag, " R5 req"}, {31'd0, fetch_req_o}, 32'd1);
      chk({tag, " R5 addr"}, fetch_addr_o, tgt);
      chk({tag, " R5 ip held"}, ip_o, exp_ip);
      chk({tag, " R9 no done"}, {31'd0, done_o}, 32'd0);
      for (int k = 0; k < wait_n; k++) begin
        word0_i   = {16'h0000, 8'hFF, 8'h00};
        word1_i   = ~tgt;
        rx_byte_i = 8'h00;
        eval_i    = 1'b1;
        step();
        eval_i = 1'b0;
        chk({tag, " R5 req held"}, {31'd0, fetch_req_o}, 32'd1);
        chk({tag, " R7 addr kept"}, fetch_addr_o, tgt);
        chk({tag, " R7 ip kept"}, ip_o, exp_ip);
        chk({tag, " R9 done low"}, {31'd0, done_o}, 32'd0);
      end
      fetch_rdy_i = 1'b1;
      step();
      fetch_rdy_i = 1'b0;
      exp_ip = tgt + 32'd4;
      chk({tag, " R6 ip land"}, ip_o, exp_ip);
      chk({tag, " R6 done"}, {31'd0, done_o}, 32'd1);
      chk({tag, " R6 req drop"}, {31'd0, fetch_req_o}, 32'd0);
    end
    step();
    chk({tag, " R9 done pulse"}, {31'd0, done_o}, 32'd0);
    chk({tag, " R3 match kept"}, {31'd0, match_o}, {31'd0, exp_match});
    chk({tag, " R3 ip idle"}, ip_o, exp_ip);
  endtask

  task automatic t_reset();
    step();
    chk("R8 ip in reset", ip_o, 32'd0);
    chk("R8 match in reset", {31'd0, match_o}, 32'd0);
    chk("R8 req in reset", {31'd0, fetch_req_o}, 32'd0);
    chk("R8 done in reset", {31'd0, done_o}, 32'd0);
    rst_n = 1'b1;
    step();
    chk("R8 ip after release", ip_o, 32'd0);
    exp_ip = 32'd0;
  endtask

  task automatic t_exact();
    run_eval("exact miss", 16'h0000, 8'h00, 8'h5A, 8'h5B, 32'h0000_1000, 0);
    run_eval("exact hit", 16'h0000, 8'h00, 8'h5A, 8'h5A, 32'h0000_0100, 0);
  endtask

  task automatic t_top_bit();
    run_eval("topbit hit", 16'h0000, 8'h7F, 8'h80, 8'h80, 32'h0000_2000, 2);
    run_eval("topbit miss", 16'h0000, 8'h7F, 8'h80, 8'h7F, 32'h0000_3000, 0);
    run_eval("topbit hit ff", 16'h0000, 8'h7F, 8'h80, 8'hFF, 32'h0000_4440, 1);
  endtask

  task automatic t_all_masked();
    run_eval("R2 all masked", 16'h0000, 8'hFF, 8'hFF, 8'h00, 32'h1234_5670, 5);
  endtask

  task automatic t_fields();
    run_eval("R1 spare bits", 16'hA5C3, 8'h0F, 8'h30, 8'h3C, 32'h0000_8000, 0);
    run_eval("R1 nibble miss", 16'hFFFF, 8'h0F, 8'h30, 8'h2F, 32'h0000_9000, 0);
    run_eval("R1 field order", 16'h0000, 8'h00, 8'h11, 8'h00, 32'h0000_A000, 0);
  endtask

  task automatic t_wrap();
    run_eval("R10 wrap hit", 16'h0000, 8'h00, 8'hC3, 8'hC3, 32'hFFFF_FFF8, 1);
    chk("R10 land wrap", ip_o, 32'hFFFF_FFFC);
    run_eval("R10 wrap miss", 16'h0000, 8'h00, 8'hC3, 8'h3C, 32'h0000_0000, 0);
    chk("R10 skip wrap", ip_o, 32'h0000_0004);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_exact();
    t_top_bit();
    t_all_masked();
    t_fields();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule